// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a PHY management bus. Software writes a single 32-bit command word. That word holds the start pattern, the operation code, the PHY address, the register number, the turnaround pattern and, for a write, the 16-bit value. The block puts 32 preamble ones on the serial data line, then shifts the command word out MSB first against a management clock. The management clock comes from the system clock through a programmable divider.

For a read, the block releases the data line during turnaround and the data phase. It samples the 16 bits that the PHY returns into the low half of the same command/data register. Every finished frame sets a sticky completion event. Software clears that event by writing a one to it. An interrupt line follows the event when the matching mask bit is set.

A speed field of zero parks the clock and refuses new frames.

Top module: `mdio_master`

## Requirements
- R1: After reset the data register reads 0, the event register reads 0, and busy, mdc, mdio_oe and irq are all low.
- R2: A write with wr_sel=0 (data) while idle and with a nonzero speed field loads wr_data into the data register and starts a frame. busy then stays high for exactly 128*S clock cycles, where S is the speed field.
- R3: A write with wr_sel=3 (speed) stores S = wr_data[6:1]. The write is ignored while busy. During a frame mdc has a period of 2*S clock cycles, and it is low whenever the block is idle.
- R4: The serial frame is 32 ones followed by command bits 31 down to 0. Each bit is presented after an mdc fall and is valid at the next mdc rise.
- R5: A command with bits 29:28 = 2'b10 is a read. The block drives the line through command bit 18 and holds mdio_oe low for the last 18 bit times (36*S cycles). At completion, data register bits 15:0 hold the 16 bits sampled on mdc rises, and bits 31:16 keep the command.
- R6: A read from an address where no PHY answers completes with 0xFFFF in data bits 15:0, because the line idles high.
- R7: After any non-read command (for example bits 29:28 = 2'b01), the data register still holds the written word when the frame completes.
- R8: Completion sets bit 23 of the event register. A write with wr_sel=1 (event) and wr_data[23]=1 clears it. A write with wr_data[23]=0 leaves it set.
- R9: If completion and a clearing event write fall in the same cycle, the event bit ends up set.
- R10: irq equals event bit 23 AND the mask bit. The mask bit is written from wr_data[23] with wr_sel=2 (mask).
- R11: A data write while busy is ignored. The frame in flight and the command bits of the data register are not changed.
- R12: While the speed field is zero, a data write neither loads the register nor starts a frame, and mdc stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 data, 1 event, 2 mask, 3 speed |
| wr_data | input | 32 | Write value |
| data_reg | output | 32 | Command/data register contents |
| evt_reg | output | 32 | Event register (bit 23 = frame complete) |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Masked completion event |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in (line value) |

## Verification
The completion event can be set in the same cycle that software writes a one to clear it. The bench provokes this by counting 128*S cycles from the edge that accepts the command, so the clearing write lands on the edge where the final mdc fall ends the frame. The event bit must read as set afterwards, and a clearing write one cycle later must drop it. A second overlap, a command write arriving mid-frame, is judged by the captured serial stream and by the upper half of the data register, both of which must still show the first command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_SPEED = 2'd3
  } reg_sel_e;

  localparam int EVT_DONE_BIT = 23;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int PREAMBLE_BITS = 32;
  localparam int CMD_BITS = 32;
  localparam int DATA_BITS = 16;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int SPW = 6
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           run,
  input  logic [SPW-1:0] half,
  output logic           mdc,
  output logic           rise,
  output logic           fall
);
  logic [SPW-1:0] cnt_q, cnt_d;
  logic           mdc_q, mdc_d;
  logic           wrap;

  assign wrap = run && (cnt_q == (half - 1'b1));
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R3: clock parks low once the divider is stopped
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> !mdc_q);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE = PREAMBLE_BITS,
  parameter int CW  = CMD_BITS,
  parameter int DW  = DATA_BITS
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  input  logic [CW-1:0] cmd,
  input  logic          rise,
  input  logic          fall,
  input  logic          mdio_i,
  output logic          busy,
  output logic          done,
  output logic          is_read,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [DW-1:0] rdata
);
  localparam int TOTAL  = PRE + CW;
  localparam int BW     = $clog2(TOTAL);
  localparam int RD_IDX = TOTAL - DW;
  localparam int TA_IDX = RD_IDX - 2;

  logic          busy_q, busy_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [CW-1:0] sh_q, sh_d;
  logic          rd_q, rd_d;
  logic [DW-1:0] cap_q, cap_d;
  logic          last;

  assign last    = (bit_q == BW'(TOTAL - 1));
  assign busy    = busy_q;
  assign is_read = rd_q;
  assign done    = busy_q && fall && last;
  assign mdio_o  = (bit_q < BW'(PRE)) ? 1'b1 : sh_q[CW-1];
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= BW'(TA_IDX)));
  assign rdata   = cap_q;

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    cap_d  = cap_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      bit_d  = '0;
      sh_d   = cmd;
      rd_d   = (cmd[CW-3:CW-4] == OP_READ);
    end else if (busy_q) begin
      if (rise && rd_q && (bit_q >= BW'(RD_IDX)))
        cap_d = {cap_q[DW-2:0], mdio_i};
      if (fall) begin
        if (last) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
          if (bit_q >= BW'(PRE)) sh_d = sh_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      cap_q  <= cap_d;
    end
  end

  // R2: the final mdc fall ends the frame
  a_r2_done_ends: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !busy_q);
  // R5: the line is only released mid-frame for read commands
  a_r5_release_read: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(mdio_oe) && busy_q) |-> rd_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] data_reg,
  output logic [31:0] evt_reg,
  output logic        busy,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW = DATA_BITS;

  logic [1:0]     rs_q;
  logic           rst_ni;
  reg_sel_e       sel;
  logic [31:0]    data_q, data_d;
  logic           evt_q, evt_d;
  logic           mask_q, mask_d;
  logic [SPW-1:0] spd_q, spd_d;
  logic           start, done, is_read, rise, fall;
  logic [DW-1:0]  rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign sel   = reg_sel_e'(wr_sel);
  assign start = wr_en && (sel == SEL_DATA) && !busy && (spd_q != '0);

  always_comb begin
    data_d = data_q;
    if (start)                data_d = wr_data;
    else if (done && is_read) data_d[DW-1:0] = rdata;

    evt_d = evt_q;
    if (done)                                                  evt_d = 1'b1;
    else if (wr_en && (sel == SEL_EVENT) && wr_data[EVT_DONE_BIT]) evt_d = 1'b0;

    mask_d = mask_q;
    if (wr_en && (sel == SEL_MASK)) mask_d = wr_data[EVT_DONE_BIT];

    spd_d = spd_q;
    if (wr_en && (sel == SEL_SPEED) && !busy) spd_d = wr_data[SPW:1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      evt_q  <= 1'b0;
      mask_q <= 1'b0;
      spd_q  <= '0;
    end else begin
      data_q <= data_d;
      evt_q  <= evt_d;
      mask_q <= mask_d;
      spd_q  <= spd_d;
    end
  end

  mdio_clkdiv #(.SPW(SPW)) u_div (
    .clk(clk), .rst_ni(rst_ni), .run(busy), .half(spd_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_ni(rst_ni), .start(start), .cmd(wr_data),
    .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .done(done), .is_read(is_read),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
  );

  assign data_reg = data_q;
  assign evt_reg  = 32'(evt_q) << EVT_DONE_BIT;
  assign irq      = evt_q & mask_q;

  // R9: completion wins over a clear in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> evt_q);
  // R11: command half of the register is frozen during a frame
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(data_q[31:16]));
  // R12: no frame can be in flight with a zero speed field
  a_r12_no_speed_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (spd_q == '0) |-> !busy);
  // R3: mdc only toggles up inside a frame
  a_r3_mdc_in_frame: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mdc) |-> busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam logic [4:0] PHY_ON = 5'd3;

  logic        clk, rst_n, wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data, data_reg, evt_reg;
  logic        busy, irq, mdc, mdio_o, mdio_oe, mdio_i;

  int errors = 0;
  int checks = 0;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_reg(data_reg), .evt_reg(evt_reg), .busy(busy), .irq(irq),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // PHY responder and line monitor
  logic        mdc_d = 1'b0, busy_d = 1'b0, hit_q = 1'b0, phy_en = 1'b0, phy_val = 1'b1;
  logic [63:0] cap = '0;
  logic [15:0] rdv_q = '0;
  int pos = 0, cyc = 0, last_rise = 0, per_t = 0, busycnt = 0, relcnt = 0;

  function automatic logic [15:0] reg_val(input logic [4:0] r);
    return 16'h1234 + 16'(r) * 16'h0101;
  endfunction

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    mdc_d  <= mdc;
    busy_d <= busy;
    if (busy && !busy_d) begin
      busycnt <= 1;
      relcnt  <= mdio_oe ? 0 : 1;
    end else if (busy) begin
      busycnt <= busycnt + 1;
      if (!mdio_oe) relcnt <= relcnt + 1;
    end
    if (!busy) begin
      pos <= 0; phy_en <= 1'b0; last_rise <= 0;
    end else begin
      if (mdc && !mdc_d) begin
        cap <= {cap[62:0], mdio_i};
        pos <= pos + 1;
        if (last_rise != 0) per_t <= cyc - last_rise;
        last_rise <= cyc;
      end
      if (!mdc && mdc_d) begin
        if (pos == 46) begin
          hit_q <= (cap[9:5] == PHY_ON) && (cap[11:10] == 2'b10);
          rdv_q <= reg_val(cap[4:0]);
        end
        if (pos == 47) begin phy_en <= hit_q; phy_val <= 1'b0; end
        if (pos >= 48 && pos <= 63) phy_val <= rdv_q[63-pos];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // {speed[63:56], cmd[55:24], expected low half[23:8], flags[7:0]: bit1 read, bit0 phy answers}
  localparam int NV = 5;
  localparam logic [63:0] VEC [NV] = '{
    {8'd3, 32'h618A0000, 16'h1436, 8'h03},
    {8'd3, 32'h638A0000, 16'hFFFF, 8'h02},
    {8'd4, 32'h51A6BEEF, 16'hBEEF, 8'h00},
    {8'd4, 32'h61FE0000, 16'h3153, 8'h03},
    {8'd3, 32'h50020000, 16'h0000, 8'h00}
  };

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 data", data_reg, 0);
    chk("R1 event", evt_reg, 0);
    chk("R1 pins", {busy, mdc, mdio_oe, irq}, 4'b0000);

    // R12 zero speed blocks frames
    wr(2'd0, 32'h618A0000);
    chk("R12 no busy", busy, 0);
    chk("R12 no load", data_reg, 0);
    repeat (20) @(negedge clk);
    chk("R12 mdc low", {mdc, busy}, 2'b00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  sp;
      logic [31:0] cmd;
      logic [15:0] ex;
      logic        rd, hit;
      sp = VEC[v][63:56]; cmd = VEC[v][55:24]; ex = VEC[v][23:8];
      rd = VEC[v][1]; hit = VEC[v][0];
      wr(2'd3, 32'(sp) << 1);
      wr(2'd1, 32'h00800000);
      wr(2'd0, cmd);
      chk("R2 busy starts", busy, 1);
      wait_idle();
      chk("R2 frame length", busycnt, 128 * sp);
      chk("R3 mdc period", per_t, 2 * sp);
      chk("R3 mdc idle low", mdc, 0);
      chk("R4 preamble", cap[63:32], 32'hFFFFFFFF);
      if (rd) begin
        chk("R4 R5 read frame", cap[31:0], {cmd[31:18], (hit ? 2'b10 : 2'b11), ex});
        chk("R5 released cycles", relcnt, 36 * sp);
        chk(hit ? "R5 read data" : "R6 no phy", data_reg, {cmd[31:16], ex});
      end else begin
        chk("R4 write frame", cap[31:0], cmd);
        chk("R5 no release on write", relcnt, 0);
        chk("R7 write keeps register", data_reg, cmd);
      end
      chk("R8 event set", evt_reg, 32'h00800000);
    end

    // R8 writing zero leaves the event, writing one clears it
    wr(2'd1, 32'h0000FFFF);
    chk("R8 zero keeps", evt_reg, 32'h00800000);
    // R10 mask
    wr(2'd2, 32'h00800000);
    chk("R10 irq on", irq, 1);
    wr(2'd2, 32'h0);
    chk("R10 irq masked", irq, 0);
    wr(2'd1, 32'h00800000);
    chk("R8 cleared", evt_reg, 0);

    // R11 data write during frame ignored; R3 speed write during frame ignored
    wr(2'd3, 32'd3 << 1);
    wr(2'd0, 32'h618A0000);
    repeat (50) @(negedge clk);
    wr(2'd0, 32'h50020000);
    wr(2'd3, 32'd7 << 1);
    chk("R11 still busy", busy, 1);
    wait_idle();
    chk("R11 register kept", data_reg, 32'h618A1436);
    chk("R11 frame kept", cap[31:16], 16'h618A);
    chk("R3 speed held", per_t, 6);

    // R9 completion and clear in the same cycle
    wr(2'd1, 32'h00800000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h61820000;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (128 * 3 - 1) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h00800000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 frame ended", busy, 0);
    chk("R9 set wins", evt_reg, 32'h00800000);
    wr(2'd1, 32'h00800000);
    chk("R8 later clear", evt_reg, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule